// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

A synthesizable behavioural model of a pipelined synchronous burst SRAM. Each word is made of four byte lanes, and each lane is nine bits wide: eight data bits with a parity bit on top. All control inputs are active low and are captured on the rising clock edge. A cycle starts a burst through one of two address strobes. The processor strobe always reads. The controller strobe reads or writes as the write controls select. A 2-bit counter then produces the next three addresses of the four-word group, in linear or interleaved order.

Writes take effect from the registered address, data and lane mask. Read data leaves a register one clock after its address is registered. The output-enable input gates the drive-enable flag combinationally. The order select input acts asynchronously on address generation. When neither strobe nor burst advance is asserted, the address is held and the cycle reads or writes there again.

Top module: `sburst_sram`

## Requirements
- R1: While reset is asserted, and after its release until a read is registered, `dout_en` is 0.
- R2: A processor-strobe cycle (`strb_p_n`=0, `ce_n`=0) registers `addr` as the burst start and reads it. The word appears on `dout` with `dout_en`=1 after the second rising edge counted from the edge that registered the cycle's inputs.
- R3: A processor-strobe cycle with `ce_n`=1 is ignored. An ongoing burst continues at its held address as if no strobe were present.
- R4: A controller-strobe cycle with `ce_n`=0 starts a burst at `addr`. It writes if any lane is enabled and reads otherwise; a write drives no output. A controller-strobe cycle with `ce_n`=1 ends the burst, and later non-strobe cycles drive no output.
- R5: With `mode`=0 (linear), each cycle with `adv_n`=0 steps the two low address bits by +1 modulo 4, and the upper bits stay fixed.
- R6: With `mode`=1 (interleaved), the two low address bits equal the start address's low bits XORed with the 2-bit counter, which steps on each `adv_n`=0 cycle.
- R7: A cycle with no strobe and `adv_n`=1 keeps the address of the previous cycle (suspend) and repeats the access there.
- R8: Lane i is bits [9i+8:9i], with the parity bit at 9i+8. With `bwe_n`=0 and `gw_n`=1, the lanes written are exactly those with `lane_we_n[i]`=0. With `bwe_n`=1 and `gw_n`=1, the lane enables have no effect.
- R9: `gw_n`=0 writes all four lanes, whatever the values of `bwe_n` and `lane_we_n`.
- R10: `oe_n`=1 forces `dout_en` to 0 at once, without waiting for a clock edge.
- R11: A read registered on the cycle right after a write to the same address returns the newly written word.
- R12: The 2-bit counter wraps, so the fourth advance after a start returns to the start address in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Burst start address |
| wdata | input | LANES*LANE_W | Write word, four 9-bit lanes |
| ce_n | input | 1 | Chip enable, active low |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| gw_n | input | 1 | Global write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| dout | output | LANES*LANE_W | Registered read word, zero when not driven |
| dout_en | output | 1 | Output drive enable (high-impedance when 0) |

## Verification
A write and a read to the same address can fall in consecutive registered cycles. In that case the array commits the write on the same edge at which the read address becomes the current access. The bench provokes this twice: a processor read starts on the cycle after a burst write to that word, and it also follows a global write that overrides disabled lanes. The scoreboard compares the word read back with a shadow copy that the bench updates lane by lane. In the same way, the asynchronous output enable is dropped in the middle of a clock during a suspended read. The drive flag must fall in that cycle, and the pipeline must keep delivering data on the next one.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  // Access carried by the registered stage for one cycle.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ce_n,
  input  logic              strb_p_n,
  input  logic              strb_c_n,
  input  logic              adv_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              bwe_n,
  input  logic              gw_n,
  output logic [ADDR_W-1:0] base_q,
  output logic [1:0]        cnt_q,
  output logic              active_q,
  output op_e               op_q,
  output logic [LANES-1:0]  mask_q,
  output logic [WORD_W-1:0] wdata_q
);

  logic             p_start, c_start, c_desel;
  logic [LANES-1:0] req_mask;
  logic             wr_req;

  logic [ADDR_W-1:0] base_d;
  logic [1:0]        cnt_d;
  logic              active_d;
  op_e               op_d;
  logic [LANES-1:0]  mask_d;

  // Per-lane write request: global write wins over the lane enables.
  for (genvar i = 0; i < LANES; i++) begin : g_lane_req
    assign req_mask[i] = !gw_n || (!bwe_n && !lane_we_n[i]);
  end
  assign wr_req = |req_mask;

  // Processor strobe only counts when selected; it wins over the controller strobe.
  assign p_start = !strb_p_n && !ce_n;
  assign c_start = !strb_c_n && !ce_n && !p_start;
  assign c_desel = !strb_c_n &&  ce_n && !p_start;

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    op_d     = OP_NONE;
    mask_d   = '0;
    if (p_start) begin
      base_d   = addr;
      cnt_d    = 2'd0;
      active_d = 1'b1;
      op_d     = OP_RD;
    end else if (c_start) begin
      base_d   = addr;
      cnt_d    = 2'd0;
      active_d = 1'b1;
      op_d     = wr_req ? OP_WR : OP_RD;
      mask_d   = req_mask;
    end else if (c_desel) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (!adv_n) cnt_d = cnt_q + 2'd1;
      op_d   = wr_req ? OP_WR : OP_RD;
      mask_d = req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      op_q     <= OP_NONE;
      mask_q   <= '0;
    end else begin
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
      op_q     <= op_d;
      mask_q   <= mask_d;
    end
  end

  // Write data register: no reset, loaded only for write cycles.
  always_ff @(posedge clk) begin
    if (op_d == OP_WR) wdata_q <= wdata;
  end

endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen #(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        cnt,
  input  logic              mode,
  output logic [ADDR_W-1:0] burst_addr
);

  logic [1:0] low;

  // mode=1: interleaved (XOR), mode=0: linear (add, wraps in group of four).
  always_comb begin
    if (mode) low = base[1:0] ^ cnt;
    else      low = base[1:0] + cnt;
  end

  assign burst_addr = {base[ADDR_W-1:2], low};

endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [LANES-1:0]  mask,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata_q,
  output logic              rvalid_q
);

  logic [WORD_W-1:0] rd_word;

  // One storage array per lane, each with its own write enable.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (op == OP_WR && mask[i])
        lane_mem[acc_addr] <= wdata[i*LANE_W +: LANE_W];
    end
    assign rd_word[i*LANE_W +: LANE_W] = lane_mem[acc_addr];
  end

  always_ff @(posedge clk) begin
    if (op == OP_RD) rdata_q <= rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= (op == OP_RD);
  end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ce_n,
  input  logic              strb_p_n,
  input  logic              strb_c_n,
  input  logic              adv_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              bwe_n,
  input  logic              gw_n,
  input  logic              oe_n,
  input  logic              mode,
  output logic [WORD_W-1:0] dout,
  output logic              dout_en
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] burst_base;
  logic [1:0]        burst_cnt;
  logic              burst_act;
  op_e               acc_op;
  logic [LANES-1:0]  acc_mask;
  logic [WORD_W-1:0] acc_wdata;
  logic [ADDR_W-1:0] burst_addr;
  logic [WORD_W-1:0] rdata_q;
  logic              rvalid_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sbs_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr     (addr),
    .wdata    (wdata),
    .ce_n     (ce_n),
    .strb_p_n (strb_p_n),
    .strb_c_n (strb_c_n),
    .adv_n    (adv_n),
    .lane_we_n(lane_we_n),
    .bwe_n    (bwe_n),
    .gw_n     (gw_n),
    .base_q   (burst_base),
    .cnt_q    (burst_cnt),
    .active_q (burst_act),
    .op_q     (acc_op),
    .mask_q   (acc_mask),
    .wdata_q  (acc_wdata)
  );

  sbs_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .base      (burst_base),
    .cnt       (burst_cnt),
    .mode      (mode),
    .burst_addr(burst_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .op      (acc_op),
    .mask    (acc_mask),
    .acc_addr(burst_addr),
    .wdata   (acc_wdata),
    .rdata_q (rdata_q),
    .rvalid_q(rvalid_q)
  );

  // Output enable acts combinationally on the drive flag.
  assign dout_en = rvalid_q && !oe_n;
  assign dout    = dout_en ? rdata_q : '0;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              strb_p_n,
  input logic              strb_c_n,
  input logic              adv_n,
  input logic              mode,
  input logic              dout_en,
  input logic              active,
  input logic [1:0]        burst_cnt,
  input logic [ADDR_W-1:0] burst_addr
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !dout_en);

  // R4
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_c_n && ce_n && (strb_p_n || ce_n)) |=> ##1 !dout_en);

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_p_n || ce_n) && strb_c_n && adv_n)
    |=> (mode != $past(mode)) || $stable(burst_addr));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_p_n || ce_n) && strb_c_n && !adv_n && active && !mode)
    |=> mode || ((burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1)
                 && (burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]))));

  // R6
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_p_n || ce_n) && strb_c_n && !adv_n && active && mode)
    |=> !mode || ((burst_addr[1:0] ^ $past(burst_addr[1:0]))
                  == ($past(burst_cnt) ^ ($past(burst_cnt) + 2'd1))));

endmodule

bind sburst_sram sbs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .strb_p_n  (strb_p_n),
  .strb_c_n  (strb_c_n),
  .adv_n     (adv_n),
  .mode      (mode),
  .dout_en   (dout_en),
  .active    (burst_act),
  .burst_cnt (burst_cnt),
  .burst_addr(burst_addr)
);

// File: tb/sim_sburst_sram.sv
`timescale 1ns/1ps
module sim_sburst_sram;

  localparam int AW = 6;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic          ce_n = 1'b1, strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
  logic [3:0]    lane_we_n = 4'hF;
  logic          bwe_n = 1'b1, gw_n = 1'b1, oe_n = 1'b0, mode = 1'b0;
  logic [WW-1:0] dout;
  logic          dout_en;

  always #2 clk = ~clk;  // 250 MHz

  sburst_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
    .lane_we_n(lane_we_n), .bwe_n(bwe_n), .gw_n(gw_n), .oe_n(oe_n),
    .mode(mode), .dout(dout), .dout_en(dout_en)
  );

  typedef struct {
    int          due;
    bit          en;
    logic [WW-1:0] d;
    string       req;
  } item_t;

  item_t         sb[$];
  logic [WW-1:0] sh [64];
  int            pcnt = 0;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  // Monitor: compares each cycle's output against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      pcnt++;
      while (sb.size() > 0 && sb[0].due == pcnt) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (dout_en !== it.en || (it.en && dout !== it.d)) begin
          n_fail++;
          $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                   it.req, dout_en, dout, it.en, it.d);
        end
      end
    end
  end

  // Driver: one cycle of inputs; ea is the burst address the requirements give.
  task automatic step(input bit ce, sp, sc, adv, input logic [3:0] lw,
                      input bit bwe, gw, input logic [AW-1:0] a,
                      input logic [WW-1:0] d, input bit xen, input int ea,
                      input string req);
    logic [3:0] m;
    item_t it;
    @(negedge clk);
    ce_n = ce; strb_p_n = sp; strb_c_n = sc; adv_n = adv;
    lane_we_n = lw; bwe_n = bwe; gw_n = gw; addr = a; wdata = d;
    for (int i = 0; i < 4; i++) m[i] = !gw || (!bwe && !lw[i]);
    if (!sp && !ce) m = '0;  // processor strobe always reads
    for (int i = 0; i < 4; i++)
      if (m[i]) sh[ea][i*9 +: 9] = d[i*9 +: 9];
    it.due = pcnt + 2;
    it.en  = xen;
    it.d   = xen ? sh[ea] : '0;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic gap(input string req);
    step(1, 1, 0, 1, 4'hF, 1, 1, '0, '0, 0, 0, req);
  endtask

  task automatic direct(input bit ok, input string req, input logic act, input logic exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: dout_en=%0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: no drive while in reset
    direct(dout_en == 1'b0, "R1", dout_en, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: still no drive after release
    direct(dout_en == 1'b0, "R1", dout_en, 1'b0);

    // R4/R9: controller-strobe burst write, global write, linear 8..11
    step(0, 1, 0, 1, 4'hF, 1, 0, 6'd8, 36'h9_1234_5670, 0, 8,  "R4");
    step(1, 1, 1, 0, 4'hF, 1, 0, 6'd0, 36'h8_ABCD_EF01, 0, 9,  "R9");
    step(1, 1, 1, 0, 4'hF, 1, 0, 6'd0, 36'h7_0F0F_0F0F, 0, 10, "R9");
    step(1, 1, 1, 0, 4'hF, 1, 0, 6'd0, 36'h6_F0F0_F0F0, 0, 11, "R9");
    // R11: read of 11 right after its write; R2 processor start
    step(0, 0, 1, 1, 4'hF, 1, 1, 6'd11, '0, 1, 11, "R11");
    // R5: linear advance wraps in group: 8, 9, 10, then R12 back to 11
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 8,  "R5");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 9,  "R5");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 10, "R5");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 11, "R12");
    gap("R4");
    gap("R4");
    mode = 1'b1;

    // R6: interleaved from 10: 11, 8, 9, then R12 back to 10
    step(0, 0, 1, 1, 4'hF, 1, 1, 6'd10, '0, 1, 10, "R2");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 11, "R6");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 8,  "R6");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 9,  "R6");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, 1, 10, "R12");
    gap("R4");
    gap("R4");
    mode = 1'b0;

    // R7: suspend repeats the read at 9
    step(0, 0, 1, 1, 4'hF, 1, 1, 6'd9, '0, 1, 9, "R2");
    step(1, 1, 1, 1, 4'hF, 1, 1, '0, '0, 1, 9, "R7");
    step(1, 1, 1, 1, 4'hF, 1, 1, '0, '0, 1, 9, "R7");
    // R10: output enable drops the drive flag mid-cycle
    #0.3;
    direct(dout_en == 1'b1, "R10", dout_en, 1'b1);
    oe_n = 1'b1;
    #0.3;
    direct(dout_en == 1'b0, "R10", dout_en, 1'b0);
    oe_n = 1'b0;
    // R3: processor strobe with chip disabled is ignored; address stays 9
    step(1, 0, 1, 1, 4'hF, 1, 1, 6'd3, '0, 1, 9, "R3");
    // R4: deselect, then non-strobe cycles stay quiet
    gap("R4");
    step(1, 1, 1, 1, 4'hF, 1, 1, '0, '0, 0, 0, "R4");

    // R8: lane writes with parity bits, then lane enables ignored when bwe_n=1
    step(0, 1, 0, 1, 4'hF,    1, 0, 6'd20, 36'hF_FFFF_FFFF, 0, 20, "R9");
    step(0, 1, 0, 1, 4'b1010, 0, 1, 6'd20, 36'h0,           0, 20, "R8");
    step(0, 1, 0, 1, 4'b0000, 1, 1, 6'd20, 36'h0,           1, 20, "R8");
    // R9: global write overrides disabled lanes; R11 read right after
    step(0, 1, 0, 1, 4'hF,    0, 0, 6'd20, 36'h5_5A5A_A5A5, 0, 20, "R9");
    step(0, 0, 1, 1, 4'hF,    1, 1, 6'd20, '0,              1, 20, "R11");
    gap("R4");
    gap("R4");

    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule